// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive-approximation analog-to-digital converter. A start request makes it take the analog input into an external sample-and-hold, then build a binary trial code one bit at a time, from the most significant bit down. The trial code drives an external DAC. Each trial is judged by a one-bit comparator that reports whether the held input is above the DAC output. When the comparator says the input is above, the tested bit stays set. Otherwise the bit is cleared. The controller then moves one bit lower. After the least significant decision it releases the hold line and pulses done. The finished word is then available in two forms: on a parallel port, and as a serial stream, most significant bit first, marked by a valid strobe.

The sequence runs through named states. IDLE waits for a start. ACQ raises the hold request with the DAC code at zero. TRIAL presents a code and gives the DAC one clock to settle. DECIDE samples the comparator and updates the code. DONE pulses done for one cycle. The transitions are:

- IDLE to ACQ on an accepted start.
- ACQ to TRIAL, loading the most significant bit.
- TRIAL to DECIDE.
- DECIDE back to TRIAL while lower bits remain, or DECIDE to DONE after bit 0.
- DONE to IDLE.

The serial stream runs after DONE. The whole block stays busy until the last serial bit has been sent.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A start seen while busy_o is low is accepted. In the next cycle, hold_req_o is high and dac_code_o is zero.
- R2: One cycle after the acquire cycle, dac_code_o holds only its most significant bit set (value 2^(N-1)).
- R3: Each trial code is held for two cycles. The comparator is sampled in the second cycle. A high sample keeps the tested bit, a low sample clears it, and in the same update the next lower bit is set. So when bit b is under test, the bits above b equal the final result's bits, bit b is 1, and the bits below b are 0.
- R4: done_o is high exactly 2N+2 cycles after the edge that accepts start. When the comparator reports input above code, the parallel result is the largest code strictly below the input (inputs 0 and 1 both give 0, and an input of 2^N gives all ones).
- R5: done_o is high for one cycle only. result_o takes the new value in the done cycle and keeps it until the done cycle of the next conversion.
- R6: hold_req_o stays high from the acquire cycle through the last decision cycle, and is low in the done cycle.
- R7: For N cycles starting the cycle after done, ser_valid_o is high and ser_data_o carries result bits N-1 down to 0. At all other times ser_valid_o is low.
- R8: busy_o is high from the acquire cycle until the last serial bit. A start during that time is ignored: timing, codes, result and the serial stream are unchanged.
- R9: While reset is held, and just after it, busy_o, hold_req_o, done_o and ser_valid_o are low, and dac_code_o and result_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request |
| cmp_i | input | 1 | Comparator: 1 when the held input is above the DAC output |
| hold_req_o | output | 1 | Hold request to the external sample-and-hold |
| dac_code_o | output | N | Trial code to the external DAC |
| busy_o | output | 1 | Conversion or serial output in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | N | Parallel conversion result |
| ser_data_o | output | 1 | Serial result bit, most significant bit first |
| ser_valid_o | output | 1 | Marks each valid serial bit |

## Verification
The assertions assume three things about the inputs: reset is applied at the start, start is a clean synchronous level, and the comparator reflects the DAC code after one clock of settling. The bench meets all three by driving start only at the falling edge. It models the comparator from a copy of dac_code_o registered one clock late, so a controller that sampled during the settling cycle would see a stale answer. The bench changes the analog input value only while busy_o is low, so the held input stays constant through each conversion. It mixes seeded random input values with the extremes 0, 1, mid-scale, 2^N-1 and 2^N, and on some runs it pulses start during the trial phase and again during the serial phase.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ACQ    = 3'd1,
        S_TRIAL  = 3'd2,
        S_DECIDE = 3'd3,
        S_DONE   = 3'd4
    } sar_state_e;
endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          ser_busy_i,
    output sar_state_e    state_o,
    output logic [IW-1:0] bit_idx_o,
    output logic          accept_o,
    output logic          load_msb_o,
    output logic          decide_o,
    output logic          last_o,
    output logic          hold_o,
    output logic          done_o,
    output logic          busy_o
);
    localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

    sar_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i && !ser_busy_i) state_d = S_ACQ;
            end
            S_ACQ: begin
                state_d = S_TRIAL;
                idx_d   = TOP_IDX;
            end
            S_TRIAL: begin
                state_d = S_DECIDE;
            end
            S_DECIDE: begin
                if (idx_q == '0) begin
                    state_d = S_DONE;
                end else begin
                    state_d = S_TRIAL;
                    idx_d   = idx_q - 1'b1;
                end
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept_o   = 1'b0;
        load_msb_o = 1'b0;
        decide_o   = 1'b0;
        hold_o     = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            S_IDLE:   accept_o   = start_i && !ser_busy_i;
            S_ACQ:    begin hold_o = 1'b1; load_msb_o = 1'b1; end
            S_TRIAL:  hold_o     = 1'b1;
            S_DECIDE: begin hold_o = 1'b1; decide_o = 1'b1; end
            S_DONE:   done_o     = 1'b1;
            default:  ;
        endcase
    end

    assign last_o    = (idx_q == '0);
    assign busy_o    = (state_q != S_IDLE) || ser_busy_i;
    assign state_o   = state_q;
    assign bit_idx_o = idx_q;
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          load_msb_i,
    input  logic          decide_i,
    input  logic          last_i,
    input  logic [IW-1:0] bit_idx_i,
    input  logic          cmp_i,
    output logic [N-1:0]  code_o,
    output logic [N-1:0]  result_o
);
    logic [N-1:0] code_q, result_q, decided;

    // resolve the bit under test, then arm the next lower one
    always_comb begin
        decided = code_q;
        if (!cmp_i) decided[bit_idx_i] = 1'b0;
        if (!last_i) decided[bit_idx_i - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q   <= '0;
            result_q <= '0;
        end else begin
            if (clear_i) begin
                code_q <= '0;
            end else if (load_msb_i) begin
                code_q <= {1'b1, {(N-1){1'b0}}};
            end else if (decide_i) begin
                code_q <= decided;
                if (last_i) result_q <= decided;
            end
        end
    end

    assign code_o   = code_q;
    assign result_o = result_q;
endmodule

// File: rtl/sar_serializer.sv
module sar_serializer #(
    parameter int N = 8,
    localparam int CW = $clog2(N + 1)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [N-1:0] data_i,
    output logic         ser_data_o,
    output logic         ser_valid_o,
    output logic         busy_o
);
    logic [N-1:0]  shreg_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (load_i) begin
            shreg_q <= data_i;
            left_q  <= CW'(N);
        end else if (left_q != '0) begin
            shreg_q <= shreg_q << 1;
            left_q  <= left_q - 1'b1;
        end
    end

    assign ser_valid_o = (left_q != '0);
    assign ser_data_o  = ser_valid_o & shreg_q[N-1];
    assign busy_o      = ser_valid_o;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic         hold_req_o,
    output logic [N-1:0] dac_code_o,
    output logic         busy_o,
    output logic         done_o,
    output logic [N-1:0] result_o,
    output logic         ser_data_o,
    output logic         ser_valid_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    sar_state_e    state;
    logic [IW-1:0] bit_idx;
    logic          accept, load_msb, decide, last, ser_busy;

    sar_fsm #(.N(N)) i_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .ser_busy_i (ser_busy),
        .state_o    (state),
        .bit_idx_o  (bit_idx),
        .accept_o   (accept),
        .load_msb_o (load_msb),
        .decide_o   (decide),
        .last_o     (last),
        .hold_o     (hold_req_o),
        .done_o     (done_o),
        .busy_o     (busy_o)
    );

    sar_trial #(.N(N)) i_trial (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clear_i    (accept),
        .load_msb_i (load_msb),
        .decide_i   (decide),
        .last_i     (last),
        .bit_idx_i  (bit_idx),
        .cmp_i      (cmp_i),
        .code_o     (dac_code_o),
        .result_o   (result_o)
    );

    sar_serializer #(.N(N)) i_ser (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (state == S_DONE),
        .data_i      (result_o),
        .ser_data_o  (ser_data_o),
        .ser_valid_o (ser_valid_o),
        .busy_o      (ser_busy)
    );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         start_i,
    input logic         cmp_i,
    input logic         hold_req_o,
    input logic [N-1:0] dac_code_o,
    input logic         busy_o,
    input logic         done_o,
    input logic [N-1:0] result_o,
    input logic         ser_data_o,
    input logic         ser_valid_o
);
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    // R1 / R8: the hold line only rises after a start taken while idle
    p_accept_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hold_req_o) |-> ($past(start_i) && !$past(busy_o)));

    // R1: acquire cycle presents a zero code
    p_acq_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hold_req_o) |-> (dac_code_o == '0));

    // R2: second hold cycle presents the MSB alone
    p_first_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_req_o && $past(hold_req_o) && !$past(hold_req_o, 2)) |-> (dac_code_o == MSB_ONLY));

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R5: result only moves together with done
    p_result_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(result_o));

    // R6: hold released exactly as done arrives
    p_hold_span_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(hold_req_o) && !hold_req_o));

    // R7: serial stream begins right after done and never overlaps the hold
    p_ser_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ser_valid_o) |-> $past(done_o));
    p_ser_no_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ser_valid_o |-> !hold_req_o);

    // R8: hold and serial output both imply busy
    p_busy_cover_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_req_o || ser_valid_o || done_o) |-> busy_o);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.N(N)) i_chk (.*);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
    localparam int N = 8;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 2 * N + 2;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_i;
    logic         hold_req_o;
    logic [N-1:0] dac_code_o;
    logic         busy_o;
    logic         done_o;
    logic [N-1:0] result_o;
    logic         ser_data_o;
    logic         ser_valid_o;

    int checks = 0;
    int errors = 0;
    int vin = 0;
    int prev_res = 0;
    logic [N-1:0] dac_q = '0;

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    // comparator settles one clock after the code changes
    always_ff @(posedge clk_i) dac_q <= dac_code_o;
    assign cmp_i = (vin > int'(dac_q));

    sar_adc_ctrl #(.N(N)) i_sar_adc_ctrl (.*);

    function automatic int exp_result(input int v);
        if (v <= 0) return 0;
        return v - 1;
    endfunction

    // code under test for bit b, given the final result
    function automatic int exp_trial(input int res, input int b);
        int upper_mask;
        upper_mask = ((1 << N) - 1) & ~((1 << (b + 1)) - 1);
        return (res & upper_mask) | (1 << b);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_conv(input int v, input bit poke);
        int res;
        res = exp_result(v);
        vin = v;
        @(negedge clk_i);
        start_i = 1'b1;
        for (int k = 1; k <= 3 * N + 3; k++) begin
            @(negedge clk_i);
            start_i = poke && (k == 5 || k == 2 * N + 4);
            if (k == 1) check(dac_code_o == '0, "R1", int'(dac_code_o), 0);
            if (k == 2) check(int'(dac_code_o) == (1 << (N - 1)), "R2", int'(dac_code_o), 1 << (N - 1));
            if (k >= 2 && k <= 2 * N && (k % 2) == 0)
                check(int'(dac_code_o) == exp_trial(res, N - k / 2), "R3",
                      int'(dac_code_o), exp_trial(res, N - k / 2));
            check(hold_req_o == (k <= 2 * N + 1), "R6", int'(hold_req_o), int'(k <= 2 * N + 1));
            check(done_o == (k == LAT), "R4", int'(done_o), int'(k == LAT));
            if (k < LAT) check(int'(result_o) == prev_res, "R5", int'(result_o), prev_res);
            if (k >= LAT) check(int'(result_o) == res, "R4", int'(result_o), res);
            check(ser_valid_o == (k >= LAT + 1 && k <= LAT + N), "R7",
                  int'(ser_valid_o), int'(k >= LAT + 1 && k <= LAT + N));
            if (k >= LAT + 1 && k <= LAT + N)
                check(ser_data_o == res[N - 1 - (k - LAT - 1)], "R7",
                      int'(ser_data_o), int'(res[N - 1 - (k - LAT - 1)]));
            check(busy_o == (k <= LAT + N), "R8", int'(busy_o), int'(k <= LAT + N));
        end
        start_i = 1'b0;
        prev_res = res;
        repeat (2) @(negedge clk_i);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk_i);
        // R9: reset values
        check(!busy_o && !hold_req_o && !done_o && !ser_valid_o, "R9", int'(busy_o), 0);
        check(dac_code_o == '0 && result_o == '0, "R9", int'(result_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check(!busy_o && !hold_req_o && dac_code_o == '0, "R9", int'(busy_o), 0);

        run_conv(0, 1'b0);
        run_conv(1, 1'b0);
        run_conv(1 << N, 1'b1);
        run_conv((1 << N) - 1, 1'b0);
        run_conv(1 << (N - 1), 1'b1);
        run_conv((1 << (N - 1)) + 1, 1'b0);
        for (int i = 0; i < 40; i++)
            run_conv(int'($urandom % ((1 << N) + 1)), 1'($urandom % 2));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule